// File: doc/BRIEF.md
# Precharged Dual-Rail Logic Cell

This block is one combinational cell of a small dual-rail library, built only from ordinary single-ended gates. Each logical signal travels as a pair of wires, a true rail and a false rail. A parameter picks the function: 2-input AND, 2-input OR, 2-input XOR, or an inverter.

A shared precharge input gates both output rails. While precharge is high, the output pair is held at the null code (0,0). While precharge is low, the cell evaluates and raises exactly one rail. The false rail is built as the De Morgan dual of the true rail, using the false-rail inputs. The inverter contains no logic gate: it exchanges the input rails before the precharge gating.

Around the cell sits a small monitor. It raises a flag for an illegal input pair and another for an illegal output pair. A registered flag reports any rail that falls during an evaluation phase, which means that rail switched more than once.

Top module: `dr_gate`

## Requirements
- R1: While `pre` is 1, both `z_t` and `z_f` are 0 for every input pattern.
- R2: Encoding: logical 1 is the pair (t=1,f=0) and logical 0 is (t=0,f=1). With `CELL`=0 (AND) and `pre` 0, the output (z_t,z_f) for inputs a,b of 00, 01 and 10 is (0,1), and for 11 it is (1,0). The false rail is the OR of the false inputs.
- R3: With `CELL`=1 (OR) and `pre` 0, `z_t` is a OR b. `z_f` is the AND of `a_f` and `b_f`.
- R4: With `CELL`=2 (XOR) and `pre` 0, `z_t` is a XOR b and `z_f` is its complement.
- R5: With `CELL`=3 (inverter) and `pre` 0, `z_t` equals `a_f` and `z_f` equals `a_t`. The b pair has no effect on the outputs or on `in_err`.
- R6: While `pre` is 0 and every used input pair is a valid code, exactly one output rail is 1.
- R7: `in_err` is 1 exactly when a used input pair is (1,1). The b pair is unused only when `CELL` is 3.
- R8: `code_err` is 1 in any of three cases: the output pair is (1,1); a rail is 1 during precharge; or the output is (0,0) while `pre` is 0 and the inputs are valid. A null input (0,0) during evaluation is not an error.
- R9: `multi_sw` pulses for one cycle after a clock edge under two conditions. First, `pre` was 0 at both that edge and the previous edge. Second, an output rail sampled 1 at the previous edge is sampled 0 at that edge. Rails falling because precharge has begun are never flagged.
- R10: While `rst_n` is 0, `multi_sw` is 0 and the rail history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the transition monitor |
| rst_n | input | 1 | Active-low synchronous reset of the monitor |
| pre | input | 1 | Precharge control; 1 forces the null output |
| a_t | input | 1 | Operand a, true rail |
| a_f | input | 1 | Operand a, false rail |
| b_t | input | 1 | Operand b, true rail (unused by the inverter) |
| b_f | input | 1 | Operand b, false rail (unused by the inverter) |
| z_t | output | 1 | Result, true rail |
| z_f | output | 1 | Result, false rail |
| in_err | output | 1 | A used input pair is (1,1) |
| code_err | output | 1 | Output pair is not legal for the current phase |
| multi_sw | output | 1 | A rail fell during evaluation (registered pulse) |

## Verification
The cell itself holds no state. A wrong gate term therefore appears on `z_t`/`z_f` as soon as the inputs settle in the same evaluation phase, and it usually also raises `code_err` at once. The only state is the rail history of the monitor. If that history is wrong, `multi_sw` fires spuriously or stays silent on the edge after the disturbance, so one clock later. Staged input arrival is driven so that the monitor's verdict can be told apart across the four cells within the same phase.

// File: rtl/dr_gate.sv
module dr_gate #(
  parameter int CELL = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pre,
  input  logic a_t,
  input  logic a_f,
  input  logic b_t,
  input  logic b_f,
  output logic z_t,
  output logic z_f,
  output logic in_err,
  output logic code_err,
  output logic multi_sw
);

  logic t_raw, f_raw, b_used;
  logic in_valid;
  logic zt_q, zf_q, pre_q;

  generate
    if (CELL == 0) begin : g_and
      assign t_raw  = a_t & b_t;
      assign f_raw  = a_f | b_f;
      assign b_used = 1'b1;
    end else if (CELL == 1) begin : g_or
      assign t_raw  = a_t | b_t;
      assign f_raw  = a_f & b_f;
      assign b_used = 1'b1;
    end else if (CELL == 2) begin : g_xor
      assign t_raw  = (a_t & b_f) | (a_f & b_t);
      assign f_raw  = (a_t & b_t) | (a_f & b_f);
      assign b_used = 1'b1;
    end else begin : g_inv
      assign t_raw  = a_f;
      assign f_raw  = a_t;
      assign b_used = 1'b0;
      p_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pre |-> (z_t == a_f && z_f == a_t));
    end
  endgenerate

  assign z_t = t_raw & ~pre;
  assign z_f = f_raw & ~pre;

  assign in_err   = (a_t & a_f) | (b_used & b_t & b_f);
  assign in_valid = (a_t ^ a_f) & (~b_used | (b_t ^ b_f));
  assign code_err = (z_t & z_f) | (pre & (z_t | z_f)) | (~pre & in_valid & ~z_t & ~z_f);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zt_q     <= 1'b0;
      zf_q     <= 1'b0;
      pre_q    <= 1'b1;
      multi_sw <= 1'b0;
    end else begin
      zt_q     <= z_t;
      zf_q     <= z_f;
      pre_q    <= pre;
      multi_sw <= ~pre & ~pre_q & ((zt_q & ~z_t) | (zf_q & ~z_f));
    end
  end

  p_null_in_precharge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pre |-> (!z_t && !z_f));

  p_one_hot_eval_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre && in_valid) |-> $onehot({z_t, z_f}));

  p_legal_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre && in_valid) |-> !code_err);

  p_no_flag_after_precharge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pre) |-> !multi_sw);

endmodule

// File: tb/dr_gate_tb.sv
module dr_gate_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pre = 1'b1;
  logic a_t = 1'b0, a_f = 1'b0, b_t = 1'b0, b_f = 1'b0;
  logic [3:0] z_t, z_f, in_err, code_err, multi_sw;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar g = 0; g < 4; g++) begin : g_cell
    dr_gate #(.CELL(g)) u_dut (
      .clk(clk), .rst_n(rst_n), .pre(pre),
      .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
      .z_t(z_t[g]), .z_f(z_f[g]), .in_err(in_err[g]),
      .code_err(code_err[g]), .multi_sw(multi_sw[g])
    );
  end

  // {cell[1:0], a, b, expected logical output}
  localparam logic [4:0] VEC [16] = '{
    5'b00_00_0, 5'b00_01_0, 5'b00_10_0, 5'b00_11_1,
    5'b01_00_0, 5'b01_01_1, 5'b01_10_1, 5'b01_11_1,
    5'b10_00_0, 5'b10_01_1, 5'b10_10_1, 5'b10_11_0,
    5'b11_00_1, 5'b11_01_1, 5'b11_10_0, 5'b11_11_0
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit a, input bit b);
    a_t = a; a_f = !a; b_t = b; b_f = !b;
  endtask

  function automatic string tag(input int c);
    case (c)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R10 multi_sw in reset", multi_sw, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 16; i++) begin
      int c;
      bit e;
      c = VEC[i][4:3];
      e = VEC[i][0];
      @(negedge clk);
      pre = 1'b1;
      drive(VEC[i][2], VEC[i][1]);
      #1;
      chk("R1 z_t in precharge", z_t[c], 0);
      chk("R1 z_f in precharge", z_f[c], 0);
      chk("R8 code_err in precharge", code_err[c], 0);
      pre = 1'b0;
      #1;
      chk({tag(c), " z_t"}, z_t[c], e);
      chk({tag(c), " z_f"}, z_f[c], !e);
      chk("R6 one rail high", z_t[c] ^ z_f[c], 1);
      chk("R8 no code_err", code_err[c], 0);
      chk("R7 no in_err", in_err[c], 0);
    end

    // illegal a pair
    @(negedge clk);
    pre = 1'b0;
    a_t = 1; a_f = 1; b_t = 1; b_f = 0;
    #1;
    chk("R7 in_err AND bad a", in_err[0], 1);
    chk("R7 in_err INV bad a", in_err[3], 1);
    chk("R8 code_err AND (1,1) out", code_err[0], 1);

    // inverter ignores b
    a_t = 1; a_f = 0; b_t = 1; b_f = 1;
    #1;
    chk("R7 INV ignores bad b", in_err[3], 0);
    chk("R5 INV z_t with bad b", z_t[3], 0);
    chk("R5 INV z_f with bad b", z_f[3], 1);
    chk("R7 AND flags bad b", in_err[0], 1);

    // pending input during evaluation
    b_t = 0; b_f = 0;
    #1;
    chk("R8 null b no code_err", code_err[0], 0);
    chk("R8 INV valid a", code_err[3], 0);

    // rail falls during evaluation
    @(negedge clk);
    pre = 1'b1; a_t = 0; a_f = 0; b_t = 0; b_f = 0;
    @(negedge clk);
    pre = 1'b0; drive(1, 0);
    @(negedge clk);
    drive(1, 1);
    @(posedge clk);
    #1;
    chk("R9 XOR rail fell", multi_sw[2], 1);
    chk("R9 AND rail fell", multi_sw[0], 1);
    chk("R9 OR steady", multi_sw[1], 0);
    chk("R9 INV steady", multi_sw[3], 0);
    @(posedge clk);
    #1;
    chk("R9 pulse one cycle", multi_sw[2], 0);

    // monotone arrival: no flag
    @(negedge clk);
    pre = 1'b1; a_t = 0; a_f = 0; b_t = 0; b_f = 0;
    @(negedge clk);
    pre = 1'b0; a_t = 1; a_f = 0;
    @(negedge clk);
    b_t = 1; b_f = 0;
    @(posedge clk);
    #1;
    chk("R9 AND monotone", multi_sw[0], 0);
    chk("R9 XOR monotone", multi_sw[2], 0);

    // entering precharge is not flagged
    @(negedge clk);
    pre = 1'b1;
    @(posedge clk);
    #1;
    chk("R9 precharge fall", multi_sw, 0);

    // reset suppresses the flag
    @(negedge clk);
    pre = 1'b0; drive(1, 0);
    @(negedge clk);
    rst_n = 1'b0;
    drive(1, 1);
    @(posedge clk);
    #1;
    chk("R10 no flag in reset", multi_sw, 0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule